// File: doc/BRIEF.md
# Calendar Alarm and Interrupt Pin Controller

This block watches a running calendar and raises an alarm when the time reaches a programmed moment. Six alarm fields (seconds, minutes, hours, day of month, month, weekday) each carry their own enable. Only the enabled fields take part in the compare. A match sets an alarm status bit. Two further status bits record low-supply and low-battery events reported by neighbouring logic. Software can clear each status bit with a write. As an option, a read of the status clears all three bits at once.

A single active-low open-drain request pin is shared between two uses. When alarm interrupts are selected, the pin reports the alarm in one of two ways. In single-event mode it stays low until software clears the alarm bit. In pulsed mode it goes low for a fixed window after every match. When alarm interrupts are not selected, the pin instead carries a square wave divided down from the 32.768 kHz clock, chosen by a 4-bit code. Code 0 releases the pin. With alarm interrupts off and code 0, the alarm still works in polled form: the status bit is set and the pin is left alone.

The timekeeping counters and the serial register access are outside this block. The current time, a 32.768 kHz tick strobe, a once-per-second strobe and all control fields arrive as direct inputs.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: A time word packs the fields as sec [5:0], min [11:6], hour [16:12], date [21:17], month [25:22], weekday [28:26]. `alm_en` bits 0..5 enable these fields in that same order. A match event occurs on a cycle with `sec_tick` high when every enabled field of `cur_time` equals the same field of `alm_time`. The event sets status bit 0 (alarm) on that clock edge.
- R2: With `alm_en` all zero, no match event ever occurs.
- R3: An event occurs only on entry into a match. If the previous `sec_tick` already matched, another matching `sec_tick` raises no new event.
- R4: Status bits are [0] alarm, [1] low supply and [2] low battery. A `lvdd_evt` or `lbat_evt` pulse sets bit 1 or bit 2 on the next edge. Reset clears all status bits and releases `irq_oe`.
- R5: A `stat_wr` clears each status bit whose `stat_wdata` bit is 0 and keeps each bit whose `stat_wdata` bit is 1. A set event in the same cycle wins over the clear.
- R6: When `auto_clr` is 1, a `stat_rd` pulse clears all status bits on the next edge. When `auto_clr` is 0, `stat_rd` has no effect.
- R7: Single-event mode is `alm_irq_en`=1 and `pulse_mode`=0. In this mode `irq_oe` is asserted from the edge of the match event until the alarm bit is cleared.
- R8: Pulsed mode is `alm_irq_en`=1 and `pulse_mode`=1. In this mode `irq_oe` is asserted from the event edge for exactly PULSE_TICKS `tick_32k` strobes, whatever the alarm bit holds. Every later match event starts a new window.
- R9: With `alm_irq_en`=0 and `freq_sel`=0, match events still set the alarm bit, but `irq_oe` stays deasserted.
- R10: With `alm_irq_en`=0 and `freq_sel`=c with c nonzero, `irq_oe` is a square wave that changes state once every 2^(c-1) `tick_32k` strobes, for an output of 32768/2^c Hz. Code 15 gives 1 Hz.
- R11: With `alm_irq_en`=1, the `freq_sel` code has no effect on `irq_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| sec_tick | input | 1 | One-cycle strobe marking a new value on cur_time |
| cur_time | input | 29 | Current calendar time (layout in R1) |
| alm_time | input | 29 | Programmed alarm time (layout in R1) |
| alm_en | input | 6 | Per-field alarm enables |
| alm_irq_en | input | 1 | 1: pin reports the alarm; 0: pin carries the frequency output |
| pulse_mode | input | 1 | 1: pulsed interrupt; 0: single-event interrupt |
| auto_clr | input | 1 | Clear the status bits on a status read |
| freq_sel | input | 4 | Frequency code for the shared pin |
| lvdd_evt | input | 1 | Low-supply event strobe |
| lbat_evt | input | 1 | Low-battery event strobe |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Status write data (0 clears a bit) |
| status | output | 3 | Status bits |
| irq_oe | output | 1 | Pin pull-down enable (1 drives the pin low) |

## Verification
The assertions take for granted that `sec_tick` and the status strobes last exactly one cycle. They also assume that the control fields do not change while a check that spans one edge is open. The alarm-bit check relies on the alarm event never coinciding with a write or read that clears the bit. The bench keeps inside these limits by driving every input on the falling edge. It raises each strobe for exactly one cycle and changes configuration only between stimulus steps. Before each compare vector it applies a neutral time that matches no alarm field, so the match history never carries over from one vector to the next.

// File: rtl/aic_pkg.sv
package aic_pkg;

    localparam int NFIELD = 6;
    localparam int TIME_W = 29;
    localparam int STAT_W = 3;
    localparam int FSEL_W = 4;
    localparam int DIV_W  = (1 << FSEL_W) - 1;

    localparam int ST_ALM  = 0;
    localparam int ST_LVDD = 1;
    localparam int ST_LBAT = 2;

    typedef struct packed {
        logic [2:0] dow;
        logic [3:0] month;
        logic [4:0] date;
        logic [4:0] hour;
        logic [5:0] minute;
        logic [5:0] second;
    } cal_time_t;

    typedef enum logic [1:0] {
        PIN_FREQ   = 2'd0,
        PIN_SINGLE = 2'd1,
        PIN_PULSE  = 2'd2
    } pin_src_e;

    function automatic logic [NFIELD-1:0] field_eq(cal_time_t a, cal_time_t b);
        field_eq[0] = (a.second == b.second);
        field_eq[1] = (a.minute == b.minute);
        field_eq[2] = (a.hour   == b.hour);
        field_eq[3] = (a.date   == b.date);
        field_eq[4] = (a.month  == b.month);
        field_eq[5] = (a.dow    == b.dow);
    endfunction

endpackage

// File: rtl/aic_match.sv
module aic_match
    import aic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  cal_time_t         now_t,
    input  cal_time_t         alm_t,
    input  logic [NFIELD-1:0] en,
    output logic              hit
);
    logic [NFIELD-1:0] eq;
    logic              all_ok;
    logic              prev_q;

    always_comb begin
        eq     = field_eq(now_t, alm_t);
        all_ok = (&(eq | ~en)) && (|en);
        hit    = sec_tick && all_ok && !prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else if (sec_tick)
            prev_q <= all_ok;
    end

    // R2: an event needs at least one enabled field
    assert_hit_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        hit |-> (en != '0));

    // R3: two back-to-back matching seconds give only one event
    assert_single_entry_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> (sec_tick && $stable(now_t) && $stable(alm_t) && $stable(en)) |-> !hit);
endmodule

// File: rtl/aic_status.sv
module aic_status
    import aic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_i,
    input  logic              wr_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic              auto_clr_i,
    output logic [STAT_W-1:0] q
);
    logic [STAT_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (wr_i)
            nxt = nxt & wdata_i;
        if (rd_i && auto_clr_i)
            nxt = '0;
        nxt = nxt | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    // R1 / R5: a set event always lands, even against a clear
    assert_set_lands_R5: assert property (@(posedge clk) disable iff (rst)
        set_i[ST_ALM] |=> q[ST_ALM]);

    // R6: read with auto clear and no new event empties the status
    assert_auto_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_i && auto_clr_i && set_i == '0) |=> (q == '0));

    // R6: read without auto clear and without other traffic keeps the status
    assert_read_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !auto_clr_i && !wr_i) |=> (q == ($past(q) | $past(set_i))));
endmodule

// File: rtl/aic_pulse.sv
module aic_pulse #(
    parameter int PULSE_TICKS = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick,
    output logic active
);
    localparam int CW = $clog2(PULSE_TICKS + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(PULSE_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_V;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R8: a window opens only from a match event
    assert_window_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(load));

    // R8: a window closes only on a 32k tick
    assert_window_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(tick));
endmodule

// File: rtl/aic_freq.sv
module aic_freq
    import aic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [FSEL_W-1:0] sel,
    output logic              pull_low
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   taps;

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (tick)
            div_q <= div_q + 1'b1;
    end

    always_comb begin
        taps     = {div_q, 1'b1};
        pull_low = !taps[sel];
    end

    // R10: the divider output changes state only on a 32k tick
    assert_freq_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
        ($stable(sel) && !$past(tick)) |-> $stable(pull_low));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import aic_pkg::*;
#(
    parameter int PULSE_TICKS = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_32k,
    input  logic              sec_tick,
    input  logic [TIME_W-1:0] cur_time,
    input  logic [TIME_W-1:0] alm_time,
    input  logic [NFIELD-1:0] alm_en,
    input  logic              alm_irq_en,
    input  logic              pulse_mode,
    input  logic              auto_clr,
    input  logic [FSEL_W-1:0] freq_sel,
    input  logic              lvdd_evt,
    input  logic              lbat_evt,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] status,
    output logic              irq_oe
);
    logic              hit;
    logic [STAT_W-1:0] set_v;
    logic              pulse_on;
    logic              freq_low;
    pin_src_e          src;

    aic_match u_match (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .now_t    (cal_time_t'(cur_time)),
        .alm_t    (cal_time_t'(alm_time)),
        .en       (alm_en),
        .hit      (hit)
    );

    always_comb begin
        set_v          = '0;
        set_v[ST_ALM]  = hit;
        set_v[ST_LVDD] = lvdd_evt;
        set_v[ST_LBAT] = lbat_evt;
    end

    aic_status u_status (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_v),
        .wr_i       (stat_wr),
        .wdata_i    (stat_wdata),
        .rd_i       (stat_rd),
        .auto_clr_i (auto_clr),
        .q          (status)
    );

    aic_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .load   (hit),
        .tick   (tick_32k),
        .active (pulse_on)
    );

    aic_freq u_freq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_32k),
        .sel      (freq_sel),
        .pull_low (freq_low)
    );

    always_comb begin
        if (!alm_irq_en)
            src = PIN_FREQ;
        else if (pulse_mode)
            src = PIN_PULSE;
        else
            src = PIN_SINGLE;

        unique case (src)
            PIN_SINGLE: irq_oe = status[ST_ALM];
            PIN_PULSE:  irq_oe = pulse_on;
            default:    irq_oe = freq_low;
        endcase
    end

    // R9: polled alarm never touches the pin
    assert_polled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!alm_irq_en && freq_sel == '0) |-> !irq_oe);

    // R7: in single mode the pin releases together with the alarm bit
    assert_single_release_R7: assert property (@(posedge clk) disable iff (rst)
        (alm_irq_en && !pulse_mode && $past(alm_irq_en && !pulse_mode) && $fell(status[ST_ALM]))
        |-> !irq_oe);
endmodule

// File: tb/alarm_irq_ctrl_bench.sv
module alarm_irq_ctrl_bench;
    localparam int PT = 8192;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_32k, sec_tick;
    logic [28:0] cur_time, alm_time;
    logic [5:0]  alm_en;
    logic        alm_irq_en, pulse_mode, auto_clr;
    logic [3:0]  freq_sel;
    logic        lvdd_evt, lbat_evt, stat_rd, stat_wr;
    logic [2:0]  stat_wdata;
    logic [2:0]  status;
    logic        irq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alarm_irq_ctrl #(.PULSE_TICKS(PT)) u_alarm_irq_ctrl (
        .clk(clk), .rst(rst), .tick_32k(tick_32k), .sec_tick(sec_tick),
        .cur_time(cur_time), .alm_time(alm_time), .alm_en(alm_en),
        .alm_irq_en(alm_irq_en), .pulse_mode(pulse_mode), .auto_clr(auto_clr),
        .freq_sel(freq_sel), .lvdd_evt(lvdd_evt), .lbat_evt(lbat_evt),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .status(status), .irq_oe(irq_oe)
    );

    // time word: {dow[2:0], month[3:0], date[4:0], hour[4:0], min[5:0], sec[5:0]}
    localparam logic [28:0] ALM  = {3'd3, 4'd1, 5'd1, 5'd11, 6'd30, 6'd0};
    localparam logic [28:0] NEUT = {3'd6, 4'd11, 5'd30, 5'd22, 6'd58, 6'd58};

    // entry: {enables[5:0], time[28:0], expected alarm}
    localparam int NV = 12;
    localparam logic [35:0] VEC [NV] = '{
        {6'b111111, 3'd3, 4'd1, 5'd1, 5'd11, 6'd30, 6'd0, 1'b1},
        {6'b111111, 3'd3, 4'd1, 5'd1, 5'd11, 6'd30, 6'd1, 1'b0},
        {6'b000010, 3'd2, 4'd5, 5'd7, 5'd3, 6'd30, 6'd5, 1'b1},
        {6'b000000, 3'd3, 4'd1, 5'd1, 5'd11, 6'd30, 6'd0, 1'b0},
        {6'b100000, 3'd3, 4'd9, 5'd20, 5'd17, 6'd2, 6'd44, 1'b1},
        {6'b011111, 3'd5, 4'd1, 5'd1, 5'd11, 6'd30, 6'd0, 1'b1},
        {6'b001000, 3'd3, 4'd1, 5'd2, 5'd11, 6'd30, 6'd0, 1'b0},
        {6'b010000, 3'd0, 4'd1, 5'd15, 5'd4, 6'd4, 6'd4, 1'b1},
        {6'b000100, 3'd1, 4'd2, 5'd3, 5'd11, 6'd9, 6'd9, 1'b1},
        {6'b000001, 3'd6, 4'd7, 5'd8, 5'd9, 6'd10, 6'd0, 1'b1},
        {6'b000110, 3'd3, 4'd1, 5'd1, 5'd11, 6'd31, 6'd0, 1'b0},
        {6'b111110, 3'd3, 4'd1, 5'd1, 5'd11, 6'd30, 6'd17, 1'b1}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply_time(logic [28:0] t);
        @(negedge clk);
        cur_time = t;
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_32k = 1'b1;
            @(negedge clk);
            tick_32k = 1'b0;
        end
    endtask

    task automatic wr_status(logic [2:0] d);
        @(negedge clk);
        stat_wr = 1'b1;
        stat_wdata = d;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic rd_status();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        tick_32k = 0; sec_tick = 0; cur_time = NEUT; alm_time = ALM;
        alm_en = '0; alm_irq_en = 0; pulse_mode = 0; auto_clr = 0;
        freq_sel = '0; lvdd_evt = 0; lbat_evt = 0; stat_rd = 0;
        stat_wr = 0; stat_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R4 reset status", status, 3'b000);
        check("R4 reset pin", irq_oe, 1'b0);

        // R1 R2: field compare vectors
        for (int v = 0; v < NV; v++) begin
            alm_en = VEC[v][35:30];
            apply_time(NEUT);
            wr_status(3'b000);
            apply_time(VEC[v][29:1]);
            check($sformatf("R1 R2 vector %0d", v), status[0], VEC[v][0]);
            wr_status(3'b000);
        end

        // R3: a second matching second with seconds masked gives no event
        alm_en = 6'b000010;
        apply_time(NEUT);
        apply_time({3'd0, 4'd2, 5'd2, 5'd2, 6'd30, 6'd1});
        check("R3 first entry", status[0], 1'b1);
        wr_status(3'b000);
        apply_time({3'd0, 4'd2, 5'd2, 5'd2, 6'd30, 6'd2});
        check("R3 no repeat", status[0], 1'b0);

        // R9: polled alarm sets bit, pin idle
        apply_time(NEUT);
        apply_time({3'd0, 4'd2, 5'd2, 5'd2, 6'd30, 6'd3});
        check("R9 polled bit", status[0], 1'b1);
        check("R9 polled pin", irq_oe, 1'b0);

        // R7: single mode pin follows the alarm bit
        alm_irq_en = 1'b1;
        @(negedge clk);
        check("R7 pin low while set", irq_oe, 1'b1);
        ticks(20);
        check("R7 pin held", irq_oe, 1'b1);
        wr_status(3'b111);
        check("R5 write one keeps", status[0], 1'b1);
        wr_status(3'b110);
        check("R5 write zero clears", status, 3'b000);
        check("R7 pin released", irq_oe, 1'b0);

        // R11: frequency code ignored in alarm mode
        freq_sel = 4'd1;
        ticks(16);
        check("R11 freq ignored", irq_oe, 1'b0);
        freq_sel = 4'd0;

        // R8: pulsed window of PT ticks, then a new match restarts it
        pulse_mode = 1'b1;
        apply_time(NEUT);
        apply_time({3'd0, 4'd2, 5'd2, 5'd2, 6'd30, 6'd4});
        check("R8 pin on after event", irq_oe, 1'b1);
        wr_status(3'b000);
        ticks(PT - 1);
        check("R8 pin still on", irq_oe, 1'b1);
        ticks(1);
        check("R8 pin off after window", irq_oe, 1'b0);
        apply_time(NEUT);
        apply_time({3'd0, 4'd2, 5'd2, 5'd2, 6'd30, 6'd5});
        check("R8 repeat fire", irq_oe, 1'b1);
        ticks(PT);
        check("R8 repeat window end", irq_oe, 1'b0);
        pulse_mode = 1'b0;
        alm_irq_en = 1'b0;
        wr_status(3'b000);

        // R4 R6: supply events and auto clear
        @(negedge clk);
        lvdd_evt = 1'b1;
        @(negedge clk);
        lvdd_evt = 1'b0;
        lbat_evt = 1'b1;
        @(negedge clk);
        lbat_evt = 1'b0;
        check("R4 supply bits", status, 3'b110);
        rd_status();
        check("R6 read no auto clear", status, 3'b110);
        auto_clr = 1'b1;
        rd_status();
        check("R6 auto clear", status, 3'b000);
        auto_clr = 1'b0;

        // R5: set wins over clear in the same cycle
        @(negedge clk);
        stat_wr = 1'b1;
        stat_wdata = 3'b000;
        lbat_evt = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0;
        lbat_evt = 1'b0;
        check("R5 set beats clear", status, 3'b100);
        wr_status(3'b000);

        // R10: frequency output transitions over 64 ticks
        for (int c = 1; c <= 6; c++) begin
            int tr;
            logic pv;
            freq_sel = 4'(c);
            @(negedge clk);
            pv = irq_oe;
            tr = 0;
            for (int i = 0; i < 64; i++) begin
                ticks(1);
                if (irq_oe !== pv) tr++;
                pv = irq_oe;
            end
            check($sformatf("R10 code %0d toggles", c), tr, 64 >> (c - 1));
        end
        freq_sel = 4'd0;
        @(negedge clk);
        check("R10 code zero released", irq_oe, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule